// File: doc/BRIEF.md
# Edge-Detecting Interrupt Flag Controller

This block gathers eleven level status signals from a clock-control unit and turns each 0-to-1 change into a sticky interrupt flag. Every flag has its own enable bit. A single shared request line goes high while any flag is set and also enabled. A wake output follows the same condition, so that any source can bring the system out of a low-power state.

Software reaches three registers through a plain synchronous port: address, write strobe, write data and read data. The flag register clears flags when 1s are written to it. The enable-set register turns enables on and the enable-clear register turns them off, also by writing 1s. Because every source shares one request line, software reads the flag register to learn which events are pending. The status inputs must already be synchronous to `clk`.

Status and flag bit order, from bit 0 upward:
- bit 0: crystal oscillator ready
- bit 1: 16 MHz internal oscillator ready
- bits 2 to 6: frequency-locked loop ready, out of bounds, fine lock, coarse lock, reference clock stopped
- bits 7 to 10: phase-locked loop lock rise, lock fall, lock timer timeout, divider ratio update complete

Top module: `osc_irq_ctrl`

## Requirements
- R1: When `rst` is high at a rising clock edge, all flags and all enables become 0 and the previous-sample state becomes 0. After that edge `irq_o` and `wake_o` are 0.
- R2: At a clock edge where `status_i[i]` is 1 and was 0 at the previous edge (or the previous edge was a reset edge), flag bit i becomes 1. It stays 1 until it is cleared. Bit i of the flags matches bit i of `status_i`, in the order listed above.
- R3: A status input that stays high sets its flag only once. After that flag is cleared, it stays 0 until the input falls and rises again.
- R4: A write (`reg_we`=1) to address 0 clears every flag whose `reg_wdata` bit is 1. Bits written as 0 leave their flags unchanged.
- R5: A write to address 1 sets every enable whose `reg_wdata` bit is 1. A write to address 2 clears every enable whose `reg_wdata` bit is 1. Bits written as 0 leave their enables unchanged.
- R6: `reg_rdata` is combinational from `reg_addr`. It shows the flags at address 0 and the enable mask at address 1 and at address 2. It shows 0 at address 3.
- R7: `irq_o` is 1 exactly when some flag bit and the matching enable bit are both 1. It falls in the cycle after the last such flag is cleared or the last such enable is cleared.
- R8: `wake_o` always equals `irq_o`.
- R9: If a rising edge on a source and a clear of that same flag happen at the same clock edge, the flag ends up set.
- R10: A status input that is already high when reset is released sets its flag at the first edge after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register and sampling clock |
| rst | input | 1 | Synchronous reset, active high |
| status_i | input | 11 | Level status bits, synchronous to clk |
| reg_addr | input | 2 | Register select: 0 flags, 1 enable set, 2 enable clear |
| reg_we | input | 1 | Write strobe, acts at the rising edge |
| reg_wdata | input | 11 | Write data, each 1 bit acts on its source |
| reg_rdata | output | 11 | Read data for reg_addr |
| irq_o | output | 1 | Shared interrupt request |
| wake_o | output | 1 | Wake-up request |

## Verification
Two functions can act on the same flag in one cycle: setting it from a rising edge and clearing it through a write to address 0. The bench forces this by raising a status bit in the same cycle as a clear write that names that bit. It then reads address 0 and expects the bit to still be set. Random stimulus also makes these collisions, and the same-cycle overlap of enable writes with flag activity. A behavioural model that is compared on every clock judges all of these cases.

// File: rtl/osc_irq_pkg.sv
package osc_irq_pkg;
  localparam int ADDR_W = 2;
  localparam logic [ADDR_W-1:0] REG_FLAG  = 2'd0;
  localparam logic [ADDR_W-1:0] REG_ENSET = 2'd1;
  localparam logic [ADDR_W-1:0] REG_ENCLR = 2'd2;
endpackage

// File: rtl/osc_irq_edge.sv
module osc_irq_edge #(
  parameter int NUM_SRC = 11
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] status_i,
  output logic [NUM_SRC-1:0] rise_o
);
  logic [NUM_SRC-1:0] prev_q;

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst) prev_q[g] <= 1'b0;
      else     prev_q[g] <= status_i[g];
    end
    assign rise_o[g] = status_i[g] & ~prev_q[g];
  end

  // R3
  steady_high_no_rise_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((rise_o & $past(status_i)) == '0));
endmodule

// File: rtl/osc_irq_flags.sv
module osc_irq_flags #(
  parameter int NUM_SRC = 11
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] rise_i,
  input  logic [NUM_SRC-1:0] clr_i,
  output logic [NUM_SRC-1:0] flag_o
);
  logic [NUM_SRC-1:0] flag_q;

  always_ff @(posedge clk) begin
    if (rst) flag_q <= '0;
    else     flag_q <= (flag_q & ~clr_i) | rise_i;
  end
  assign flag_o = flag_q;

  // R2 R9
  edge_sets_flag_chk: assert property (@(posedge clk) disable iff (rst)
    (rise_i != '0) |=> ((flag_q & $past(rise_i)) == $past(rise_i)));
  // R4
  clear_drops_flag_chk: assert property (@(posedge clk) disable iff (rst)
    ((clr_i & ~rise_i) != '0) |=> ((flag_q & $past(clr_i & ~rise_i)) == '0));
  // R2
  no_spurious_flag_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((flag_q & ~$past(flag_q) & ~$past(rise_i)) == '0));
endmodule

// File: rtl/osc_irq_enables.sv
module osc_irq_enables #(
  parameter int NUM_SRC = 11
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] set_i,
  input  logic [NUM_SRC-1:0] clr_i,
  output logic [NUM_SRC-1:0] en_o
);
  logic [NUM_SRC-1:0] en_q;

  always_ff @(posedge clk) begin
    if (rst) en_q <= '0;
    else     en_q <= (en_q | set_i) & ~clr_i;
  end
  assign en_o = en_q;

  // R5
  enable_set_chk: assert property (@(posedge clk) disable iff (rst)
    (set_i != '0) |=> ((en_q & $past(set_i)) == $past(set_i)));
  // R5
  enable_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (clr_i != '0) |=> ((en_q & $past(clr_i)) == '0));
  // R5
  enable_hold_chk: assert property (@(posedge clk) disable iff (rst)
    ((set_i | clr_i) == '0) |=> (en_q == $past(en_q)));
endmodule

// File: rtl/osc_irq_ctrl.sv
module osc_irq_ctrl
  import osc_irq_pkg::*;
#(
  parameter int NUM_SRC = 11
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_SRC-1:0]  status_i,
  input  logic [ADDR_W-1:0]   reg_addr,
  input  logic                reg_we,
  input  logic [NUM_SRC-1:0]  reg_wdata,
  output logic [NUM_SRC-1:0]  reg_rdata,
  output logic                irq_o,
  output logic                wake_o
);
  logic [NUM_SRC-1:0] rise;
  logic [NUM_SRC-1:0] flags;
  logic [NUM_SRC-1:0] en;
  logic [NUM_SRC-1:0] flag_clr;
  logic [NUM_SRC-1:0] en_set;
  logic [NUM_SRC-1:0] en_clr;
  logic [NUM_SRC-1:0] pending;

  assign flag_clr = (reg_we && reg_addr == REG_FLAG)  ? reg_wdata : '0;
  assign en_set   = (reg_we && reg_addr == REG_ENSET) ? reg_wdata : '0;
  assign en_clr   = (reg_we && reg_addr == REG_ENCLR) ? reg_wdata : '0;

  osc_irq_edge #(.NUM_SRC(NUM_SRC)) u_edge (
    .clk(clk), .rst(rst), .status_i(status_i), .rise_o(rise)
  );

  osc_irq_flags #(.NUM_SRC(NUM_SRC)) u_flags (
    .clk(clk), .rst(rst), .rise_i(rise), .clr_i(flag_clr), .flag_o(flags)
  );

  osc_irq_enables #(.NUM_SRC(NUM_SRC)) u_en (
    .clk(clk), .rst(rst), .set_i(en_set), .clr_i(en_clr), .en_o(en)
  );

  always_comb begin
    unique case (reg_addr)
      REG_FLAG:             reg_rdata = flags;
      REG_ENSET, REG_ENCLR: reg_rdata = en;
      default:              reg_rdata = '0;
    endcase
  end

  assign pending = flags & en;
  assign irq_o   = |pending;
  assign wake_o  = pending != '0;

  // R7
  irq_needs_enable_chk: assert property (@(posedge clk) disable iff (rst)
    (en == '0) |-> !irq_o);
  // R7
  irq_needs_flag_chk: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> (flags != '0));
  // R8
  wake_matches_irq_chk: assert property (@(posedge clk) disable iff (rst)
    wake_o == irq_o);
  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    rst |=> (!irq_o && flags == '0 && en == '0));
endmodule

// File: tb/osc_irq_ctrl_tb.sv
module osc_irq_ctrl_tb;
  localparam int N = 11;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [N-1:0] status_i = '0;
  logic [1:0]   reg_addr = '0;
  logic         reg_we = 1'b0;
  logic [N-1:0] reg_wdata = '0;
  logic [N-1:0] reg_rdata;
  logic         irq_o, wake_o;

  int n_chk = 0;
  int n_bad = 0;

  // behavioural reference state
  bit [N-1:0] m_prev, m_flag, m_en;

  always #4 clk = ~clk;

  osc_irq_ctrl u_dut (
    .clk(clk), .rst(rst), .status_i(status_i), .reg_addr(reg_addr),
    .reg_we(reg_we), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq_o(irq_o), .wake_o(wake_o)
  );

  always @(posedge clk) begin
    if (rst) begin
      m_prev = '0; m_flag = '0; m_en = '0;
    end else begin
      for (int i = 0; i < N; i++) begin
        bit up;
        up = status_i[i] && !m_prev[i];
        if (reg_we && reg_addr == 2'd0 && reg_wdata[i]) m_flag[i] = 1'b0;
        if (up) m_flag[i] = 1'b1;
        if (reg_we && reg_addr == 2'd1 && reg_wdata[i]) m_en[i] = 1'b1;
        if (reg_we && reg_addr == 2'd2 && reg_wdata[i]) m_en[i] = 1'b0;
        m_prev[i] = status_i[i];
      end
    end
  end

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got=%0h exp=%0h at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic compare_all();
    bit [N-1:0] exp_rd;
    bit exp_irq;
    exp_irq = (m_flag & m_en) != '0;
    case (reg_addr)
      2'd0: exp_rd = m_flag;
      2'd1, 2'd2: exp_rd = m_en;
      default: exp_rd = '0;
    endcase
    chk("R6 rdata", 32'(reg_rdata), 32'(exp_rd));
    chk("R7 irq", 32'(irq_o), 32'(exp_irq));
    chk("R8 wake", 32'(wake_o), 32'(exp_irq));
  endtask

  // apply inputs for one clock, then compare after the following falling edge
  task automatic step(input logic [N-1:0] st, input logic [1:0] a,
                      input logic we, input logic [N-1:0] wd);
    status_i = st; reg_addr = a; reg_we = we; reg_wdata = wd;
    @(negedge clk); #1;
    compare_all();
  endtask

  task automatic peek(input logic [1:0] a, input logic [N-1:0] st, output logic [N-1:0] rd);
    step(st, a, 1'b0, '0);
    rd = reg_rdata;
  endtask

  initial begin
    #(8 * 150000);
    n_bad++;
    $display("FAIL watchdog expired got=hung exp=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [N-1:0] rd;
    // R10: bit 0 high through reset
    status_i = 11'h001;
    repeat (3) @(negedge clk);
    rst = 1'b1;
    @(negedge clk); #1;
    // R1 reset state
    chk("R1 irq after reset", 32'(irq_o), 0);
    reg_addr = 2'd1; #1;
    chk("R1 enables after reset", 32'(reg_rdata), 0);
    rst = 1'b0;
    peek(2'd0, 11'h001, rd);
    chk("R10 flag from high-at-reset input", 32'(rd), 32'h001);
    peek(2'd0, 11'h001, rd);
    chk("R3 steady high keeps single flag", 32'(rd), 32'h001);
    chk("R7 no irq while disabled", 32'(irq_o), 0);
    step(11'h001, 2'd0, 1'b1, 11'h001);
    peek(2'd0, 11'h001, rd);
    chk("R3 steady high does not re-set", 32'(rd), 0);
    // R2: rising edge on bit 10 sets its flag
    step(11'h001, 2'd0, 1'b0, '0);
    peek(2'd0, 11'h401, rd);
    chk("R2 edge on bit 10", 32'(rd), 32'h400);
    // R5: enable set, read at both enable addresses
    step(11'h401, 2'd1, 1'b1, 11'h480);
    peek(2'd2, 11'h401, rd);
    chk("R5 enable set mask", 32'(rd), 32'h480);
    chk("R7 irq on enabled flag", 32'(irq_o), 1);
    chk("R8 wake on enabled flag", 32'(wake_o), 1);
    // R5: zero bits leave enables unchanged
    step(11'h401, 2'd1, 1'b1, '0);
    peek(2'd1, 11'h401, rd);
    chk("R5 zero write no effect", 32'(rd), 32'h480);
    // R7: disable drops irq
    step(11'h401, 2'd2, 1'b1, 11'h400);
    chk("R7 irq drops after disable", 32'(irq_o), 0);
    peek(2'd1, 11'h401, rd);
    chk("R5 enable clear mask", 32'(rd), 32'h080);
    // R4: zero write to flags keeps them
    step(11'h401, 2'd0, 1'b1, 11'h000);
    peek(2'd0, 11'h401, rd);
    chk("R4 zero write keeps flags", 32'(rd), 32'h400);
    // R9: rise on bit 7 together with clear of bit 7
    step(11'h000, 2'd0, 1'b0, '0);
    step(11'h080, 2'd0, 1'b1, 11'h480);
    peek(2'd0, 11'h080, rd);
    chk("R9 collision keeps flag", 32'(rd), 32'h080);
    chk("R7 irq from bit 7", 32'(irq_o), 1);
    // R7: clearing the flag drops irq
    step(11'h080, 2'd0, 1'b1, 11'h080);
    chk("R7 irq drops after flag clear", 32'(irq_o), 0);
    // R6: address 3 reads zero
    peek(2'd3, 11'h080, rd);
    chk("R6 unused address reads zero", 32'(rd), 0);
    // random traffic compared every clock
    for (int k = 0; k < 3000; k++) begin
      logic [N-1:0] st, wd;
      logic [1:0] a;
      st = N'($urandom);
      wd = N'($urandom);
      a  = 2'($urandom);
      if (($urandom % 200) == 0) begin
        rst = 1'b1;
        step(st, a, 1'b0, wd);
        rst = 1'b0;
      end else begin
        step(st, a, 1'($urandom), wd);
      end
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule